// File: doc/BRIEF.md
# Multi-Channel DMA Register Front-End

This block is the bus-facing register slave of a multi-channel DMA controller. Software reaches it over a simple 32-bit read/write bus. It keeps, for every channel, a control/status word, a control-block address, the fields of the control block the engine has loaded, and an error word. Two global words sit beside them: an interrupt summary and a channel enable mask. The per-channel transfer engines sit behind the block. They get start, run, abort and reset controls from it. They report completion, error causes, request/hold/wait status and loaded control-block fields back to it.

The control/status word mixes run control with sticky flags. Writing 1 to the run bit starts the channel. Writing 0 to it pauses a running channel. The completion and interrupt flags are cleared by writing 1 to them. Abort and reset are one-cycle strobes that always read back as 0. When a transfer finishes and the loaded next-block address is non-zero, the front-end moves that address into the control-block address, keeps the channel running and restarts its engine.

Top module: `dma_reg_front`

## Requirements
- R1: Channel c decodes at byte address c*0x100 plus offset: status 0x00, block address 0x04, info 0x08, source 0x0C, destination 0x10, length 0x14, stride 0x18, next 0x1C, error 0x20. The block address is read/write, and read data appears on `bus_rdata` one cycle after the read access.
- R2: Status bits: run 0, end 1, int 2, request 3, paused 4, held 5, waiting 6, error 8, wait-writes 28, no-debug 29, abort 30, reset 31. After reset every channel's status word reads 0 and `eng_run`, `eng_start` and `irq` are 0.
- R3: Writing 1 to status bit 0 of an idle, enabled channel sets the run bit and `eng_run`, and pulses `eng_start` for exactly one cycle.
- R4: Writing 0 to bit 0 while the channel runs drops `eng_run` and sets paused (bit 4). Writing 1 again resumes the channel, clears paused and pulses `eng_start`.
- R5: The enable word at 0xFF0 has one bit per channel and resets to all ones. A channel whose bit is 0 ignores a write of 1 to its run bit: there is no `eng_start` pulse and the status stays unchanged.
- R6: A completion from the engine while the channel runs sets end. With the next field at 0 it also clears run. It sets int only if info bit 0 is 1. Int drives `irq[c]` and bit c of the summary word at 0xFE0.
- R7: A completion with a non-zero next field copies next into the block address, keeps run at 1, sets end and pulses `eng_start` again.
- R8: Writing 1 to status bit 1 or 2 clears end or int, and writing 0 there leaves them unchanged. Writing 1 to bit c of 0xFE0 clears channel c's int.
- R9: When a completion sets int in the same cycle that software clears it, int ends up set.
- R10: Error codes reported by the engine OR into bits 2:0 of the error word, and writing 1 clears a bit (a new report in that cycle wins). Status bit 8 is 1 while any of these bits is set. Status bits 3, 5 and 6 follow the engine's request, hold and wait inputs (`eng_flags` bits 0, 1, 2 per channel).
- R11: Writing status bit 30 pulses `eng_abort` for one cycle. Writing bit 31 pulses `eng_reset` for one cycle and clears run, end, int, paused, wait-writes, no-debug and the error word. Both bits read 0.
- R12: The engine load port writes info, source, destination, length, stride or next using field codes 0 to 5. Bus writes to those offsets have no effect.
- R13: Reads of an unmapped address (misaligned, offset above 0x20, channel index at or beyond the channel count, or any other global address) return 0, and writes to one change nothing.
- R14: Status bits 28 and 29 are plain read/write bits, updated on every status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| eng_start | output | NUM_CH | One-cycle start strobe per channel |
| eng_run | output | NUM_CH | Run level per channel (0 means pause) |
| eng_abort | output | NUM_CH | One-cycle abort strobe per channel |
| eng_reset | output | NUM_CH | One-cycle reset strobe per channel |
| eng_cbaddr | output | NUM_CH*32 | Block address per channel |
| eng_done | input | NUM_CH | Completion pulse per channel |
| eng_err | input | NUM_CH*3 | Error cause pulses, three per channel |
| eng_flags | input | NUM_CH*3 | Request, hold, wait levels per channel |
| ld_valid | input | 1 | Load-port write strobe |
| ld_chan | input | CH_W | Channel index for the load |
| ld_field | input | 3 | Field code 0..5 |
| ld_data | input | 32 | Loaded field value |
| irq | output | NUM_CH | Interrupt per channel |

## Verification
Two pairs of events can land in the same clock edge: an engine completion that sets int while a status write clears int, and an engine error report while software clears the same error bit. The bench drives the completion strobe or error code in the very cycle the bus write is presented. It then judges the result at the ports: `irq` must stay high, and the status and error words read back through the bus must show the set value. A chained completion is checked by observing the restart strobe and the new block address.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ERR_W  = 3;

    // status word bit positions
    localparam int ST_RUN    = 0;
    localparam int ST_END    = 1;
    localparam int ST_INT    = 2;
    localparam int ST_REQ    = 3;
    localparam int ST_PAUSED = 4;
    localparam int ST_HELD   = 5;
    localparam int ST_WAIT   = 6;
    localparam int ST_ERROR  = 8;
    localparam int ST_WWR    = 28;
    localparam int ST_NODBG  = 29;
    localparam int ST_ABORT  = 30;
    localparam int ST_RESET  = 31;

    // word index inside a channel window (offset / 4)
    localparam logic [3:0] IX_STATUS = 4'd0;
    localparam logic [3:0] IX_CBADDR = 4'd1;
    localparam logic [3:0] IX_INFO   = 4'd2;
    localparam logic [3:0] IX_SRC    = 4'd3;
    localparam logic [3:0] IX_DST    = 4'd4;
    localparam logic [3:0] IX_LEN    = 4'd5;
    localparam logic [3:0] IX_STRIDE = 4'd6;
    localparam logic [3:0] IX_NEXT   = 4'd7;
    localparam logic [3:0] IX_ERRW   = 4'd8;

    // load-port field codes
    localparam logic [2:0] LF_INFO   = 3'd0;
    localparam logic [2:0] LF_SRC    = 3'd1;
    localparam logic [2:0] LF_DST    = 3'd2;
    localparam logic [2:0] LF_LEN    = 3'd3;
    localparam logic [2:0] LF_STRIDE = 3'd4;
    localparam logic [2:0] LF_NEXT   = 3'd5;

    localparam logic [ADDR_W-1:0] A_IRQ_SUM = 12'hFE0;
    localparam logic [ADDR_W-1:0] A_CH_EN   = 12'hFF0;

    typedef struct packed {
        logic       hit;
        logic       is_chan;
        logic       is_sum;
        logic       is_en;
        logic [3:0] chan;
        logic [3:0] idx;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] cbaddr;
        logic [DATA_W-1:0] info;
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] len;
        logic [DATA_W-1:0] stride;
        logic [DATA_W-1:0] nxt;
        logic [DATA_W-1:0] errw;
    } chan_view_t;

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
    import dma_regs_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec      = '0;
        dec.chan = addr[11:8];
        dec.idx  = addr[5:2];
        if (addr == A_IRQ_SUM) begin
            dec.is_sum = 1'b1;
        end else if (addr == A_CH_EN) begin
            dec.is_en = 1'b1;
        end else if (addr[1:0] == 2'b00 && int'(addr[11:8]) < NUM_CH
                     && addr[7:2] <= 6'd8) begin
            dec.is_chan = 1'b1;
        end
        dec.hit = dec.is_sum | dec.is_en | dec.is_chan;
    end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              chan_en,
    input  logic              sum_clr,
    input  logic              ld_en,
    input  logic [2:0]        ld_field,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              done,
    input  logic [ERR_W-1:0]  err_code,
    input  logic [2:0]        flags,
    output chan_view_t        view,
    output logic              start,
    output logic              run,
    output logic              abort,
    output logic              rst_pulse,
    output logic              int_flag,
    output logic [DATA_W-1:0] cbaddr
);

    typedef struct packed {
        logic              run;
        logic              end_f;
        logic              int_f;
        logic              paused;
        logic              wwr;
        logic              nodbg;
        logic [ERR_W-1:0]  errs;
        logic [DATA_W-1:0] cbaddr;
        logic [DATA_W-1:0] info;
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] len;
        logic [DATA_W-1:0] stride;
        logic [DATA_W-1:0] nxt;
        logic              start;
        logic              abort;
        logic              rst;
    } cstate_t;

    cstate_t st_d, st_q;
    logic    st_wr;

    assign st_wr = wr_en && (wr_idx == IX_STATUS);

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.abort = 1'b0;
        st_d.rst   = 1'b0;

        if (st_wr) begin
            if (wdata[ST_RUN]) begin
                if (!st_q.run && chan_en) begin
                    st_d.run    = 1'b1;
                    st_d.start  = 1'b1;
                    st_d.paused = 1'b0;
                end
            end else begin
                if (st_q.run) st_d.paused = 1'b1;
                st_d.run = 1'b0;
            end
            if (wdata[ST_END]) st_d.end_f = 1'b0;
            if (wdata[ST_INT]) st_d.int_f = 1'b0;
            st_d.wwr   = wdata[ST_WWR];
            st_d.nodbg = wdata[ST_NODBG];
            st_d.abort = wdata[ST_ABORT];
        end
        if (sum_clr) st_d.int_f = 1'b0;

        if (wr_en && wr_idx == IX_CBADDR) st_d.cbaddr = wdata;
        if (wr_en && wr_idx == IX_ERRW) st_d.errs = st_q.errs & ~wdata[ERR_W-1:0];
        st_d.errs = st_d.errs | err_code;

        if (ld_en) begin
            case (ld_field)
                LF_INFO:   st_d.info   = ld_data;
                LF_SRC:    st_d.src    = ld_data;
                LF_DST:    st_d.dst    = ld_data;
                LF_LEN:    st_d.len    = ld_data;
                LF_STRIDE: st_d.stride = ld_data;
                LF_NEXT:   st_d.nxt    = ld_data;
                default: ;
            endcase
        end

        // engine completion: set flags win over a software clear
        if (done && st_q.run) begin
            st_d.end_f = 1'b1;
            if (st_q.info[0]) st_d.int_f = 1'b1;
            if (st_q.nxt != '0) begin
                st_d.cbaddr = st_q.nxt;
                st_d.start  = st_d.run;
            end else begin
                st_d.run    = 1'b0;
                st_d.paused = 1'b0;
            end
        end

        // channel reset overrides everything else
        if (st_wr && wdata[ST_RESET]) begin
            st_d.run    = 1'b0;
            st_d.end_f  = 1'b0;
            st_d.int_f  = 1'b0;
            st_d.paused = 1'b0;
            st_d.wwr    = 1'b0;
            st_d.nodbg  = 1'b0;
            st_d.errs   = '0;
            st_d.start  = 1'b0;
            st_d.abort  = 1'b0;
            st_d.rst    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        view                   = '0;
        view.status[ST_RUN]    = st_q.run;
        view.status[ST_END]    = st_q.end_f;
        view.status[ST_INT]    = st_q.int_f;
        view.status[ST_REQ]    = flags[0];
        view.status[ST_PAUSED] = st_q.paused;
        view.status[ST_HELD]   = flags[1];
        view.status[ST_WAIT]   = flags[2];
        view.status[ST_ERROR]  = |st_q.errs;
        view.status[ST_WWR]    = st_q.wwr;
        view.status[ST_NODBG]  = st_q.nodbg;
        view.cbaddr            = st_q.cbaddr;
        view.info              = st_q.info;
        view.src               = st_q.src;
        view.dst               = st_q.dst;
        view.len               = st_q.len;
        view.stride            = st_q.stride;
        view.nxt               = st_q.nxt;
        view.errw[ERR_W-1:0]   = st_q.errs;
    end

    assign start     = st_q.start;
    assign run       = st_q.run;
    assign abort     = st_q.abort;
    assign rst_pulse = st_q.rst;
    assign int_flag  = st_q.int_f;
    assign cbaddr    = st_q.cbaddr;

    // R3
    start_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |-> st_q.run);

    // R4
    paused_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.paused |-> !st_q.run);

    // R6
    int_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.int_f) |-> $past(done && st_q.info[0]));

    // R11
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_wr && wdata[ST_RESET]) |-> (!st_q.run && !st_q.int_f && st_q.errs == '0));

endmodule

// File: rtl/dma_reg_front.sv
module dma_reg_front
    import dma_regs_pkg::*;
#(
    parameter int  NUM_CH = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NUM_CH-1:0]        eng_start,
    output logic [NUM_CH-1:0]        eng_run,
    output logic [NUM_CH-1:0]        eng_abort,
    output logic [NUM_CH-1:0]        eng_reset,
    output logic [NUM_CH*DATA_W-1:0] eng_cbaddr,
    input  logic [NUM_CH-1:0]        eng_done,
    input  logic [NUM_CH*ERR_W-1:0]  eng_err,
    input  logic [NUM_CH*3-1:0]      eng_flags,
    input  logic                     ld_valid,
    input  logic [CH_W-1:0]          ld_chan,
    input  logic [2:0]               ld_field,
    input  logic [DATA_W-1:0]        ld_data,
    output logic [NUM_CH-1:0]        irq
);

    typedef struct packed {
        logic [NUM_CH-1:0] en;
        logic [DATA_W-1:0] rdata;
    } tstate_t;

    tstate_t           ts_d, ts_q;
    dec_t              dec;
    chan_view_t        views [NUM_CH];
    logic [NUM_CH-1:0] int_vec;
    logic [NUM_CH-1:0] sum_clr;
    logic              wr_acc, rd_acc;

    assign wr_acc  = bus_sel && bus_wr;
    assign rd_acc  = bus_sel && !bus_wr;
    assign sum_clr = (wr_acc && dec.is_sum) ? bus_wdata[NUM_CH-1:0] : '0;

    dma_addr_decode #(.NUM_CH(NUM_CH)) i_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic ch_wr, ch_ld;
        assign ch_wr = wr_acc && dec.is_chan && (dec.chan == 4'(g));
        assign ch_ld = ld_valid && (ld_chan == CH_W'(g));

        dma_chan_regs i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (ch_wr),
            .wr_idx    (dec.idx),
            .wdata     (bus_wdata),
            .chan_en   (ts_q.en[g]),
            .sum_clr   (sum_clr[g]),
            .ld_en     (ch_ld),
            .ld_field  (ld_field),
            .ld_data   (ld_data),
            .done      (eng_done[g]),
            .err_code  (eng_err[g*ERR_W +: ERR_W]),
            .flags     (eng_flags[g*3 +: 3]),
            .view      (views[g]),
            .start     (eng_start[g]),
            .run       (eng_run[g]),
            .abort     (eng_abort[g]),
            .rst_pulse (eng_reset[g]),
            .int_flag  (int_vec[g]),
            .cbaddr    (eng_cbaddr[g*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        chan_view_t        sel_view;
        logic [DATA_W-1:0] rd_val;

        sel_view = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (dec.chan == 4'(c)) sel_view = views[c];
        end

        rd_val = '0;
        if (dec.is_sum) begin
            rd_val[NUM_CH-1:0] = int_vec;
        end else if (dec.is_en) begin
            rd_val[NUM_CH-1:0] = ts_q.en;
        end else if (dec.is_chan) begin
            case (dec.idx)
                IX_STATUS: rd_val = sel_view.status;
                IX_CBADDR: rd_val = sel_view.cbaddr;
                IX_INFO:   rd_val = sel_view.info;
                IX_SRC:    rd_val = sel_view.src;
                IX_DST:    rd_val = sel_view.dst;
                IX_LEN:    rd_val = sel_view.len;
                IX_STRIDE: rd_val = sel_view.stride;
                IX_NEXT:   rd_val = sel_view.nxt;
                IX_ERRW:   rd_val = sel_view.errw;
                default:   rd_val = '0;
            endcase
        end

        ts_d = ts_q;
        if (wr_acc && dec.is_en) ts_d.en = bus_wdata[NUM_CH-1:0];
        if (rd_acc) ts_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q.en    <= '1;
            ts_q.rdata <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    assign bus_rdata = ts_q.rdata;
    assign irq       = int_vec;

    // R13
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_acc && !dec.hit) |-> bus_rdata == '0);

    // R5
    disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_acc && dec.is_chan && !eng_run[0] && dec.chan == 4'd0
              && !ts_q.en[0]) |-> !eng_start[0]);

endmodule

// File: tb/test_dma_reg_front.sv
module test_dma_reg_front;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 4;
    localparam int NVEC = 18;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCH-1:0]    eng_start, eng_run, eng_abort, eng_reset, irq;
    logic [NCH*32-1:0] eng_cbaddr;
    logic [NCH-1:0]    eng_done = '0;
    logic [NCH*3-1:0]  eng_err = '0;
    logic [NCH*3-1:0]  eng_flags = '0;
    logic              ld_valid = 1'b0;
    logic [1:0]        ld_chan = '0;
    logic [2:0]        ld_field = '0;
    logic [31:0]       ld_data = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_reg_front #(.NUM_CH(NCH)) i_dma_reg_front (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_run(eng_run), .eng_abort(eng_abort),
        .eng_reset(eng_reset), .eng_cbaddr(eng_cbaddr), .eng_done(eng_done),
        .eng_err(eng_err), .eng_flags(eng_flags), .ld_valid(ld_valid),
        .ld_chan(ld_chan), .ld_field(ld_field), .ld_data(ld_data), .irq(irq)
    );

    // {is_write, address, write data, expected read data}
    localparam logic [76:0] VEC [NVEC] = '{
        {1'b0, 12'h000, 32'h0,        32'h0},        // R2 reset status
        {1'b0, 12'hFF0, 32'h0,        32'hF},        // R5 enable reset value
        {1'b0, 12'hFE0, 32'h0,        32'h0},        // R6 summary idle
        {1'b1, 12'h104, 32'h00001000, 32'h0},        // R1
        {1'b0, 12'h104, 32'h0,        32'h00001000}, // R1
        {1'b1, 12'h204, 32'hCAFE0020, 32'h0},        // R1
        {1'b0, 12'h204, 32'h0,        32'hCAFE0020}, // R1
        {1'b1, 12'h108, 32'h12345678, 32'h0},        // R12 bus write ignored
        {1'b0, 12'h108, 32'h0,        32'h0},        // R12
        {1'b1, 12'h000, 32'h30000000, 32'h0},        // R14
        {1'b0, 12'h000, 32'h0,        32'h30000000}, // R14
        {1'b1, 12'h000, 32'h40000000, 32'h0},        // R11 abort reads 0
        {1'b0, 12'h000, 32'h0,        32'h0},        // R11
        {1'b1, 12'h024, 32'hFFFFFFFF, 32'h0},        // R13
        {1'b0, 12'h024, 32'h0,        32'h0},        // R13
        {1'b1, 12'h306, 32'hFFFFFFFF, 32'h0},        // R13 misaligned
        {1'b0, 12'h304, 32'h0,        32'h0},        // R13
        {1'b0, 12'h400, 32'h0,        32'h0}         // R13 absent channel
    };
    localparam string VREQ [NVEC] = '{
        "R2", "R5", "R6", "R1", "R1", "R1", "R1", "R12", "R12",
        "R14", "R14", "R11", "R11", "R13", "R13", "R13", "R13", "R13"
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic eload(input logic [1:0] c, input logic [2:0] f, input logic [31:0] d);
        @(negedge clk);
        ld_valid = 1'b1; ld_chan = c; ld_field = f; ld_data = d;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic pulse_done(input int c);
        @(negedge clk);
        eng_done[c] = 1'b1;
        @(negedge clk);
        eng_done[c] = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset outputs
        check("R2 run", 32'(eng_run), 32'h0);
        check("R2 start", 32'(eng_start), 32'h0);
        check("R2 irq", 32'(irq), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][76]) begin
                bwrite(VEC[i][75:64], VEC[i][63:32]);
            end else begin
                bread(VEC[i][75:64], rd);
                check(VREQ[i], rd, VEC[i][31:0]);
            end
        end

        // R12 load port, R3 start
        bwrite(12'h004, 32'h100);
        eload(2'd0, 3'd0, 32'h1);
        eload(2'd0, 3'd3, 32'h40);
        bread(12'h008, rd);  check("R12 info", rd, 32'h1);
        bread(12'h014, rd);  check("R12 len", rd, 32'h40);
        bwrite(12'h000, 32'h1);
        check("R3 start pulse", 32'(eng_start[0]), 32'h1);
        check("R3 run", 32'(eng_run[0]), 32'h1);
        @(negedge clk);
        check("R3 pulse width", 32'(eng_start[0]), 32'h0);
        bread(12'h000, rd);  check("R3 status", rd, 32'h1);

        // R4 pause and resume
        bwrite(12'h000, 32'h0);
        check("R4 run low", 32'(eng_run[0]), 32'h0);
        bread(12'h000, rd);  check("R4 paused", rd, 32'h10);
        bwrite(12'h000, 32'h1);
        check("R4 resume start", 32'(eng_start[0]), 32'h1);
        bread(12'h000, rd);  check("R4 resumed", rd, 32'h1);

        // R10 engine status inputs
        eng_flags[2:0] = 3'b111;
        bread(12'h000, rd);  check("R10 flags", rd, 32'h69);
        eng_flags[2:0] = 3'b000;

        // R6 completion with interrupt enabled
        pulse_done(0);
        check("R6 run cleared", 32'(eng_run[0]), 32'h0);
        check("R6 irq", 32'(irq), 32'h1);
        bread(12'h000, rd);  check("R6 status", rd, 32'h6);
        bread(12'hFE0, rd);  check("R6 summary", rd, 32'h1);

        // R8 write-one-to-clear
        bwrite(12'h000, 32'h0);
        bread(12'h000, rd);  check("R8 zero write", rd, 32'h6);
        bwrite(12'h000, 32'h2);
        bread(12'h000, rd);  check("R8 end clear", rd, 32'h4);
        bwrite(12'hFE0, 32'h1);
        bread(12'h000, rd);  check("R8 summary clear", rd, 32'h0);
        check("R8 irq", 32'(irq), 32'h0);

        // R7 chaining on channel 1, no interrupt
        eload(2'd1, 3'd5, 32'h2000);
        bwrite(12'h100, 32'h1);
        pulse_done(1);
        check("R7 restart", 32'(eng_start[1]), 32'h1);
        check("R7 run", 32'(eng_run[1]), 32'h1);
        check("R7 cbaddr", eng_cbaddr[63:32], 32'h2000);
        check("R7 irq", 32'(irq), 32'h0);
        bread(12'h100, rd);  check("R7 status", rd, 32'h3);

        // R9 completion sets int while software clears it
        bwrite(12'h000, 32'h1);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h4;
        eng_done[0] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; eng_done[0] = 1'b0;
        check("R9 irq kept", 32'(irq[0]), 32'h1);
        bread(12'h000, rd);  check("R9 status", rd, 32'h6);

        // R10 error word
        @(negedge clk);
        eng_err[2:0] = 3'b101;
        @(negedge clk);
        eng_err[2:0] = 3'b000;
        bread(12'h020, rd);  check("R10 errw", rd, 32'h5);
        bread(12'h000, rd);  check("R10 error bit", rd, 32'h106);
        bwrite(12'h020, 32'h1);
        bread(12'h020, rd);  check("R10 clear", rd, 32'h4);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h020; bus_wdata = 32'h6;
        eng_err[2:0] = 3'b010;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; eng_err[2:0] = 3'b000;
        bread(12'h020, rd);  check("R10 report wins", rd, 32'h2);

        // R11 abort and reset strobes
        bwrite(12'h000, 32'h40000000);
        check("R11 abort pulse", 32'(eng_abort[0]), 32'h1);
        @(negedge clk);
        check("R11 abort width", 32'(eng_abort[0]), 32'h0);
        bwrite(12'h000, 32'h80000000);
        check("R11 reset pulse", 32'(eng_reset[0]), 32'h1);
        check("R11 irq", 32'(irq), 32'h0);
        bread(12'h000, rd);  check("R11 status", rd, 32'h0);
        bread(12'h020, rd);  check("R11 errw", rd, 32'h0);

        // R5 disabled channel ignores a start
        bwrite(12'hFF0, 32'hE);
        bwrite(12'h000, 32'h1);
        check("R5 no start", 32'(eng_start[0]), 32'h0);
        bread(12'h000, rd);  check("R5 status", rd, 32'h0);
        bread(12'hFF0, rd);  check("R5 enable", rd, 32'hE);
        bwrite(12'hFF0, 32'hF);

        // R13 other global address
        bread(12'hFE4, rd);  check("R13 global gap", rd, 32'h0);

        finish_run();
    end

endmodule